// File: doc/BRIEF.md
# Pipeline hazard and forwarding unit

This unit is the hazard control for a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). It watches the register specifiers and write flags held in the four stage registers and decides where each operand should come from. For the two execute-stage ALU operands it picks between the register file, the execute/memory stage register and the memory/writeback stage register. For the two operands of the branch comparator, which sits in decode, it picks between the register file and the execute/memory stage register. A register file that writes in the first half of the cycle and reads in the second covers a result sitting in memory/writeback.

When a value cannot arrive in time, the unit holds the program counter and the fetch/decode register and turns the decode/execute register into a bubble. Branches resolve in decode with fetch continuing at the next sequential address. A taken branch clears the single wrongly fetched successor in fetch/decode. Register zero never causes forwarding or a stall.

A small state machine has two states. `ST_RUN` is normal operation. `ST_BR_LOAD_HOLD` is the second stall cycle of a branch that waits on a load. The machine takes the transition RUN→HOLD when a branch in decode reads the destination of a load in execute. It takes HOLD→RUN unconditionally one cycle later. In every other case it stays in RUN.

Top module: `hazard_fwd_unit`

## Requirements
- R1: An ALU operand whose source register equals the destination of a writing instruction in execute/memory selects code 2'b01. Code 2'b00 means the register file and 2'b10 means memory/writeback.
- R2: An ALU operand whose source matches only a writing memory/writeback destination selects code 2'b10.
- R3: When both execute/memory and memory/writeback match the same source, code 2'b01 wins.
- R4: A destination or source of register zero never forwards (code 2'b00) and never stalls.
- R5: A load in execute whose destination is read by the instruction in decode raises the PC hold, the fetch/decode hold and the decode/execute bubble for exactly that cycle. An operand that decode does not use causes no stall.
- R6: A load result in memory/writeback is forwarded (code 2'b10) to the store-data operand (operand B) of the following store in execute.
- R7: A branch-comparator operand selects execute/memory (bit 1) when a non-load writer there matches. A match only in memory/writeback leaves it at 0.
- R8: A branch in decode reading the destination of an ALU instruction in execute stalls for one cycle.
- R9: A branch in decode reading the destination of a load in execute stalls for two consecutive cycles. The second cycle comes from state ST_BR_LOAD_HOLD, whatever the other stage contents are.
- R10: A taken branch in decode that is not stalled raises the fetch/decode flush.
- R11: While the branch in decode is stalled, no flush is raised even when its outcome input reads taken.
- R12: A non-branch instruction in decode reading an ALU result in execute does not stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_rs1 | input | 5 | Decode source 1 |
| id_rs2 | input | 5 | Decode source 2 |
| id_use1 | input | 1 | Decode reads source 1 |
| id_use2 | input | 1 | Decode reads source 2 |
| id_is_branch | input | 1 | Decode holds a conditional branch |
| id_br_taken | input | 1 | Comparator outcome for the branch in decode |
| ex_rs1 | input | 5 | Execute source 1 |
| ex_rs2 | input | 5 | Execute source 2 |
| ex_rd | input | 5 | Execute destination |
| ex_wen | input | 1 | Execute writes its destination |
| ex_is_load | input | 1 | Execute holds a load |
| mem_rd | input | 5 | Execute/memory destination |
| mem_wen | input | 1 | Execute/memory writes its destination |
| mem_is_load | input | 1 | Execute/memory holds a load |
| wb_rd | input | 5 | Memory/writeback destination |
| wb_wen | input | 1 | Memory/writeback writes its destination |
| fwd_a | output | 2 | ALU operand A source select |
| fwd_b | output | 2 | ALU operand B source select |
| fwd_br_a | output | 1 | Comparator operand A from execute/memory |
| fwd_br_b | output | 1 | Comparator operand B from execute/memory |
| pc_hold | output | 1 | Hold the program counter |
| ifid_hold | output | 1 | Hold fetch/decode |
| idex_bubble | output | 1 | Load a no-op into decode/execute |
| ifid_flush | output | 1 | Clear fetch/decode to a no-op |

## Verification
The squash of a taken branch and the stall of that same branch can both be requested in one cycle. The bench sets this up by placing a taken branch in decode while the instruction producing its operand sits in execute, first as an ALU instruction and then as a load. The bench judges it cycle by cycle. While the hold signals are high, the flush must stay low. In the first cycle after the last stall, the flush must rise with the comparator operand now taken from execute/memory or from the register file.

// File: rtl/hz_pkg.sv
package hz_pkg;
    localparam int REG_AW_DEF = 5;

    typedef enum logic [1:0] {
        SRC_RF    = 2'b00,
        SRC_EXMEM = 2'b01,
        SRC_MEMWB = 2'b10
    } opnd_src_e;

    typedef enum logic {
        ST_RUN          = 1'b0,
        ST_BR_LOAD_HOLD = 1'b1
    } stall_state_e;
endpackage

// File: rtl/hz_alu_fwd.sv
module hz_alu_fwd
    import hz_pkg::*;
#(
    parameter int REG_AW = REG_AW_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] src,
    input  logic [REG_AW-1:0] mem_rd,
    input  logic              mem_wen,
    input  logic [REG_AW-1:0] wb_rd,
    input  logic              wb_wen,
    output opnd_src_e         sel
);
    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    logic hit_mem;
    logic hit_wb;

    assign hit_mem = mem_wen && (mem_rd != ZERO_REG) && (mem_rd == src);
    assign hit_wb  = wb_wen  && (wb_rd  != ZERO_REG) && (wb_rd  == src);

    always_comb begin
        if (hit_mem)      sel = SRC_EXMEM;
        else if (hit_wb)  sel = SRC_MEMWB;
        else              sel = SRC_RF;
    end

    assert_x0_no_fwd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (src == ZERO_REG) |-> (sel == SRC_RF));

    assert_newest_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wen && mem_rd == src && wb_wen && wb_rd == src && src != ZERO_REG)
        |-> (sel == SRC_EXMEM));
endmodule

// File: rtl/hz_branch_fwd.sv
module hz_branch_fwd
    import hz_pkg::*;
#(
    parameter int REG_AW = REG_AW_DEF
) (
    input  logic [REG_AW-1:0] src,
    input  logic [REG_AW-1:0] mem_rd,
    input  logic              mem_wen,
    input  logic              mem_is_load,
    output logic              from_mem
);
    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    assign from_mem = mem_wen && !mem_is_load &&
                      (mem_rd != ZERO_REG) && (mem_rd == src);
endmodule

// File: rtl/hz_stall_ctrl.sv
module hz_stall_ctrl
    import hz_pkg::*;
#(
    parameter int REG_AW = REG_AW_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] id_rs1,
    input  logic [REG_AW-1:0] id_rs2,
    input  logic              id_use1,
    input  logic              id_use2,
    input  logic              id_is_branch,
    input  logic              id_br_taken,
    input  logic [REG_AW-1:0] ex_rd,
    input  logic              ex_wen,
    input  logic              ex_is_load,
    output logic              stall,
    output logic              flush
);
    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    stall_state_e state_q;
    stall_state_e state_d;

    logic id_reads_ex;
    logic load_hit;
    logic br_alu_hit;

    assign id_reads_ex = ex_wen && (ex_rd != ZERO_REG) &&
                         ((id_use1 && id_rs1 == ex_rd) ||
                          (id_use2 && id_rs2 == ex_rd));
    assign load_hit    = ex_is_load && id_reads_ex;
    assign br_alu_hit  = id_is_branch && !ex_is_load && id_reads_ex;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        stall   = 1'b0;
        flush   = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                stall = load_hit || br_alu_hit;
                if (load_hit && id_is_branch) state_d = ST_BR_LOAD_HOLD;
            end
            ST_BR_LOAD_HOLD: begin
                stall   = 1'b1;
                state_d = ST_RUN;
            end
            default: begin
                stall   = 1'b0;
                state_d = ST_RUN;
            end
        endcase
        flush = id_is_branch && id_br_taken && !stall;
    end

    assert_br_load_two_cycles_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && id_is_branch && load_hit) |=> stall);

    assert_no_flush_while_stalled_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !flush);

    assert_hold_returns_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BR_LOAD_HOLD) |=> (state_q == ST_RUN));
endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit
    import hz_pkg::*;
#(
    parameter int REG_AW = REG_AW_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] id_rs1,
    input  logic [REG_AW-1:0] id_rs2,
    input  logic              id_use1,
    input  logic              id_use2,
    input  logic              id_is_branch,
    input  logic              id_br_taken,
    input  logic [REG_AW-1:0] ex_rs1,
    input  logic [REG_AW-1:0] ex_rs2,
    input  logic [REG_AW-1:0] ex_rd,
    input  logic              ex_wen,
    input  logic              ex_is_load,
    input  logic [REG_AW-1:0] mem_rd,
    input  logic              mem_wen,
    input  logic              mem_is_load,
    input  logic [REG_AW-1:0] wb_rd,
    input  logic              wb_wen,
    output logic [1:0]        fwd_a,
    output logic [1:0]        fwd_b,
    output logic              fwd_br_a,
    output logic              fwd_br_b,
    output logic              pc_hold,
    output logic              ifid_hold,
    output logic              idex_bubble,
    output logic              ifid_flush
);
    localparam int NUM_OPND = 2;

    logic [REG_AW-1:0] ex_src [NUM_OPND];
    logic [REG_AW-1:0] id_src [NUM_OPND];
    opnd_src_e         alu_sel [NUM_OPND];
    logic              br_sel  [NUM_OPND];
    logic              stall;
    logic              flush;

    assign ex_src[0] = ex_rs1;
    assign ex_src[1] = ex_rs2;
    assign id_src[0] = id_rs1;
    assign id_src[1] = id_rs2;

    for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
        hz_alu_fwd #(.REG_AW(REG_AW)) u_alu_fwd (
            .clk     (clk),
            .rst_n   (rst_n),
            .src     (ex_src[g]),
            .mem_rd  (mem_rd),
            .mem_wen (mem_wen),
            .wb_rd   (wb_rd),
            .wb_wen  (wb_wen),
            .sel     (alu_sel[g])
        );
        hz_branch_fwd #(.REG_AW(REG_AW)) u_br_fwd (
            .src         (id_src[g]),
            .mem_rd      (mem_rd),
            .mem_wen     (mem_wen),
            .mem_is_load (mem_is_load),
            .from_mem    (br_sel[g])
        );
    end

    hz_stall_ctrl #(.REG_AW(REG_AW)) u_stall (
        .clk          (clk),
        .rst_n        (rst_n),
        .id_rs1       (id_rs1),
        .id_rs2       (id_rs2),
        .id_use1      (id_use1),
        .id_use2      (id_use2),
        .id_is_branch (id_is_branch),
        .id_br_taken  (id_br_taken),
        .ex_rd        (ex_rd),
        .ex_wen       (ex_wen),
        .ex_is_load   (ex_is_load),
        .stall        (stall),
        .flush        (flush)
    );

    assign fwd_a       = alu_sel[0];
    assign fwd_b       = alu_sel[1];
    assign fwd_br_a    = br_sel[0];
    assign fwd_br_b    = br_sel[1];
    assign pc_hold     = stall;
    assign ifid_hold   = stall;
    assign idex_bubble = stall;
    assign ifid_flush  = flush;

    assert_loaduse_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_is_load && ex_wen && ex_rd != '0 && id_use1 && id_rs1 == ex_rd)
        |-> (pc_hold && ifid_hold && idex_bubble));

    assert_x0_never_stalls_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rd == '0 && !id_is_branch) |-> !idex_bubble);
endmodule

// File: tb/test_hazard_fwd_unit.sv
module test_hazard_fwd_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
    logic       id_use1, id_use2, id_is_branch, id_br_taken;
    logic       ex_wen, ex_is_load, mem_wen, mem_is_load, wb_wen;
    logic [1:0] fwd_a, fwd_b;
    logic       fwd_br_a, fwd_br_b, pc_hold, ifid_hold, idex_bubble, ifid_flush;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    hazard_fwd_unit i_hazard_fwd_unit (
        .clk(clk), .rst_n(rst_n),
        .id_rs1(id_rs1), .id_rs2(id_rs2), .id_use1(id_use1), .id_use2(id_use2),
        .id_is_branch(id_is_branch), .id_br_taken(id_br_taken),
        .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd), .ex_wen(ex_wen),
        .ex_is_load(ex_is_load), .mem_rd(mem_rd), .mem_wen(mem_wen),
        .mem_is_load(mem_is_load), .wb_rd(wb_rd), .wb_wen(wb_wen),
        .fwd_a(fwd_a), .fwd_b(fwd_b), .fwd_br_a(fwd_br_a), .fwd_br_b(fwd_br_b),
        .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble),
        .ifid_flush(ifid_flush)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_all();
        id_rs1 = 0; id_rs2 = 0; id_use1 = 0; id_use2 = 0;
        id_is_branch = 0; id_br_taken = 0;
        ex_rs1 = 0; ex_rs2 = 0; ex_rd = 0; ex_wen = 0; ex_is_load = 0;
        mem_rd = 0; mem_wen = 0; mem_is_load = 0; wb_rd = 0; wb_wen = 0;
    endtask

    task automatic check_stall(input string req, input logic exp);
        check({req, " pc_hold"}, pc_hold, exp);
        check({req, " ifid_hold"}, ifid_hold, exp);
        check({req, " idex_bubble"}, idex_bubble, exp);
    endtask

    // Drive at the falling edge, sample 1 ns later.
    task automatic step();
        @(negedge clk);
        clear_all();
    endtask

    task automatic t_reset();
        step(); #1;
        check("reset fwd_a", fwd_a, 2'b00);
        check("reset flush", ifid_flush, 1'b0);
        check_stall("reset", 1'b0);
    endtask

    task automatic t_exmem_fwd_r1();
        step(); ex_rs1 = 5; ex_rs2 = 6; mem_rd = 5; mem_wen = 1; #1;
        check("R1 fwd_a", fwd_a, 2'b01);
        check("R1 fwd_b", fwd_b, 2'b00);
    endtask

    task automatic t_memwb_fwd_r2();
        step(); ex_rs1 = 8; ex_rs2 = 6; wb_rd = 6; wb_wen = 1; #1;
        check("R2 fwd_b", fwd_b, 2'b10);
        check("R2 fwd_a", fwd_a, 2'b00);
        wb_wen = 0; #1;
        check("R2 no write no fwd", fwd_b, 2'b00);
    endtask

    task automatic t_priority_r3();
        step(); ex_rs1 = 7; ex_rs2 = 7; mem_rd = 7; mem_wen = 1; wb_rd = 7; wb_wen = 1; #1;
        check("R3 fwd_a", fwd_a, 2'b01);
        check("R3 fwd_b", fwd_b, 2'b01);
    endtask

    task automatic t_x0_r4();
        step(); ex_rs1 = 0; ex_rs2 = 0; mem_rd = 0; mem_wen = 1; wb_rd = 0; wb_wen = 1; #1;
        check("R4 fwd_a", fwd_a, 2'b00);
        check("R4 fwd_b", fwd_b, 2'b00);
        step(); ex_rd = 0; ex_wen = 1; ex_is_load = 1; id_rs1 = 0; id_use1 = 1; #1;
        check_stall("R4 load x0", 1'b0);
    endtask

    task automatic t_load_use_r5();
        step(); ex_rd = 3; ex_wen = 1; ex_is_load = 1; id_rs2 = 3; id_use2 = 1; #1;
        check_stall("R5 load-use", 1'b1);
        step(); mem_rd = 3; mem_wen = 1; mem_is_load = 1; id_rs2 = 3; id_use2 = 1; #1;
        check_stall("R5 one cycle only", 1'b0);
        step(); ex_rd = 3; ex_wen = 1; ex_is_load = 1; id_rs2 = 3; id_use2 = 0; #1;
        check_stall("R5 unused operand", 1'b0);
    endtask

    task automatic t_load_store_r6();
        step(); ex_rs1 = 2; ex_rs2 = 4; wb_rd = 4; wb_wen = 1; #1;
        check("R6 store data fwd", fwd_b, 2'b10);
    endtask

    task automatic t_branch_fwd_r7();
        step(); id_is_branch = 1; id_rs1 = 9; id_rs2 = 10; id_use1 = 1; id_use2 = 1;
        mem_rd = 9; mem_wen = 1; wb_rd = 10; wb_wen = 1; #1;
        check("R7 br_a from exmem", fwd_br_a, 1'b1);
        check("R7 br_b memwb via rf", fwd_br_b, 1'b0);
    endtask

    task automatic t_branch_alu_r8();
        step(); id_is_branch = 1; id_br_taken = 1; id_rs1 = 11; id_use1 = 1;
        ex_rd = 11; ex_wen = 1; #1;
        check_stall("R8 branch on alu", 1'b1);
        check("R11 no flush while stalled", ifid_flush, 1'b0);
        step(); id_is_branch = 1; id_br_taken = 1; id_rs1 = 11; id_use1 = 1;
        mem_rd = 11; mem_wen = 1; #1;
        check_stall("R8 released", 1'b0);
        check("R10 flush after stall", ifid_flush, 1'b1);
        check("R7 br_a after stall", fwd_br_a, 1'b1);
    endtask

    task automatic t_branch_load_r9();
        step(); id_is_branch = 1; id_br_taken = 1; id_rs2 = 12; id_use2 = 1;
        ex_rd = 12; ex_wen = 1; ex_is_load = 1; #1;
        check_stall("R9 first cycle", 1'b1);
        check("R11 flush first", ifid_flush, 1'b0);
        // second cycle: hold comes from the state, not from stage contents
        step(); id_is_branch = 1; id_br_taken = 1; id_rs2 = 12; id_use2 = 1; #1;
        check_stall("R9 second cycle", 1'b1);
        check("R11 flush second", ifid_flush, 1'b0);
        step(); id_is_branch = 1; id_br_taken = 1; id_rs2 = 12; id_use2 = 1;
        wb_rd = 12; wb_wen = 1; #1;
        check_stall("R9 released", 1'b0);
        check("R9 br_b from rf", fwd_br_b, 1'b0);
        check("R10 flush after load wait", ifid_flush, 1'b1);
    endtask

    task automatic t_no_stall_alu_r12();
        step(); id_rs1 = 13; id_use1 = 1; ex_rd = 13; ex_wen = 1; #1;
        check_stall("R12 alu to non-branch", 1'b0);
    endtask

    task automatic t_flush_r10();
        step(); id_is_branch = 1; id_br_taken = 1; id_rs1 = 1; id_use1 = 1; #1;
        check("R10 taken flush", ifid_flush, 1'b1);
        id_br_taken = 0; #1;
        check("R10 not taken", ifid_flush, 1'b0);
        step(); #1;
        check("R10 idle no flush", ifid_flush, 1'b0);
    endtask

    initial begin
        clear_all();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_exmem_fwd_r1();
        t_memwb_fwd_r2();
        t_priority_r3();
        t_x0_r4();
        t_load_use_r5();
        t_load_store_r6();
        t_branch_fwd_r7();
        t_branch_alu_r8();
        t_branch_load_r9();
        t_no_stall_alu_r12();
        t_flush_r10();
        step();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule